// File: doc/BRIEF.md
# Authorization Token Checker

This block is a fail-closed hardware gate that decides whether one pending action may run. A compact authorization token arrives as a fixed number of words over a valid/ready interface. The token carries an action identifier, an order size, a target, a direction bit, a logical clock value, a nonce and a message authentication tag. Alongside the token, the block sees a descriptor of the action that is about to execute and the current logical epoch.

Once the token is assembled, the block sends its covered fields (everything except the tag) to an external digest engine through a request/acknowledge port. It then compares the returned tag with the token's tag one byte per cycle, always over every byte. It then judges replay against a small table of accepted nonces, freshness against the epoch, and an exact match against the descriptor. The single `proceed_o` line rises only when every check passes, and it stays high for a fixed window that authorizes exactly one action. A latched reason code records why the last token was refused.

Key storage, the digest algorithm and any logging lie outside the block.

Top module: `auth_token_checker`

## Requirements
- R1: After reset and whenever no token has been fully accepted, `proceed_o` is low, `tok_ready_o` is high and `reason_o` is 0.
- R2: A token is NWORDS = ceil(TOK_W/WORD_W) words, most significant word first. The token value is {pad, action, size, target, dir, lclock, nonce, tag}, with the tag in the least significant TAG_W bits and the zero pad at the top being ignored. `tok_ready_o` falls only after a word transfer.
- R3: After the last word, `dig_req_o` is high with `dig_msg_o` equal to {action, size, target, dir, lclock, nonce}, and both hold until a cycle with `dig_ack_i` high, in which `dig_tag_i` is taken as the reference tag.
- R4: If the token tag differs from the reference tag in any bit, the token is refused with reason code 1.
- R5: A nonce that an earlier token used in an accepted authorization is refused with reason code 2.
- R6: A token whose lclock is below `epoch_i` is refused with reason code 3. An lclock equal to or above the epoch passes this check.
- R7: If action, size, target or dir differ from the descriptor inputs, the token is refused with reason code 4.
- R8: When several checks fail, the reported code follows the priority MAC (1) > replay (2) > stale (3) > mismatch (4) > table full (5).
- R9: The nonce table holds DEPTH entries and never evicts. An otherwise valid token arriving when DEPTH nonces are stored is refused with code 5. A refused token stores no nonce.
- R10: An accepted token sets `reason_o` to 0 and drives `proceed_o` high for exactly WIN cycles, with `tok_ready_o` low during that window. It then returns to idle.
- R11: The verdict appears a fixed TAG_W/8+1 cycles after the acknowledge cycle, whatever byte the tag mismatch sits in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_valid_i | input | 1 | Token word valid |
| tok_ready_o | output | 1 | Ready for a token word (idle) |
| tok_data_i | input | WORD_W | Token word |
| act_id_i | input | ACT_W | Pending action identifier |
| act_size_i | input | SIZE_W | Pending action size |
| act_target_i | input | TGT_W | Pending action target |
| act_dir_i | input | 1 | Pending action direction |
| epoch_i | input | CLK_W | Current logical epoch |
| dig_req_o | output | 1 | Digest request |
| dig_msg_o | output | COV_W | Covered token fields for the digest |
| dig_ack_i | input | 1 | Digest result valid |
| dig_tag_i | input | TAG_W | Reference tag from the digest engine |
| proceed_o | output | 1 | Authorization window active |
| reason_o | output | 3 | Code of the last verdict: 0 ok, 1 MAC, 2 replay, 3 stale, 4 mismatch, 5 table full |

## Verification
The hardest state to reach is a full nonce table that still answers correctly. Getting there takes DEPTH accepted tokens, each with a fresh nonce, the exact descriptor and a current clock. Only after that can the full-table refusal be seen, along with its ranking below MAC and replay faults. The stimulus runs a directed opening with ordinary refusals, then randomly faulted tokens tracked by a bench model of the stored nonces, then directed clean tokens until the table is full. After that it sends clean, MAC-faulted and replayed tokens. A refused-then-accepted nonce and tag flips in the first and last byte cover the no-consumption and constant-latency rules.

// File: rtl/auth_pkg.sv
package auth_pkg;
  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_MAC      = 3'd1,
    RSN_REPLAY   = 3'd2,
    RSN_STALE    = 3'd3,
    RSN_MISMATCH = 3'd4,
    RSN_FULL     = 3'd5
  } reason_e;

  typedef enum logic [1:0] {
    ST_RX,
    ST_DIG,
    ST_CMP,
    ST_GRANT
  } state_e;
endpackage

// File: rtl/auth_tag_cmp.sv
// Byte-serial tag compare; always walks every byte.
module auth_tag_cmp #(
  parameter int TAG_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAG_W-1:0] a_i,
  input  logic [TAG_W-1:0] b_i,
  output logic             done_o,
  output logic             match_o
);
  localparam int NB    = TAG_W / 8;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

  logic [7:0]       diff [NB];
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       acc_q;
  logic [7:0]       cur;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign diff[g] = a_i[8*g +: 8] ^ b_i[8*g +: 8];
  end

  assign cur     = diff[idx_q];
  assign done_o  = busy_q && (idx_q == LAST);
  assign match_o = ((acc_q | cur) == 8'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      acc_q  <= '0;
    end else if (busy_q) begin
      acc_q <= acc_q | cur;
      if (idx_q == LAST) busy_q <= 1'b0;
      else               idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/auth_nonce_store.sv
// Fill-only table of accepted nonces; no eviction.
module auth_nonce_store #(
  parameter int DEPTH   = 8,
  parameter int NONCE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NONCE_W-1:0] nonce_i,
  input  logic               insert_i,
  output logic               hit_o,
  output logic               full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NONCE_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]   used_q;
  logic [DEPTH-1:0]   eq;
  logic [CNT_W-1:0]   fill_q;

  assign full_o = (fill_q == CNT_W'(DEPTH));
  assign hit_o  = |(used_q & eq);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign eq[g] = (slot_q[g] == nonce_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
        used_q[g] <= 1'b0;
      end else if (insert_i && !full_o && fill_q == CNT_W'(g)) begin
        slot_q[g] <= nonce_i;
        used_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 fill_q <= '0;
    else if (insert_i && !full_o) fill_q <= fill_q + 1'b1;
  end
endmodule

// File: rtl/auth_token_checker.sv
module auth_token_checker import auth_pkg::*; #(
  parameter int WORD_W  = 32,
  parameter int ACT_W   = 8,
  parameter int SIZE_W  = 16,
  parameter int TGT_W   = 16,
  parameter int CLK_W   = 16,
  parameter int NONCE_W = 32,
  parameter int TAG_W   = 64,
  parameter int DEPTH   = 8,
  parameter int WIN     = 16
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic                                          tok_valid_i,
  output logic                                          tok_ready_o,
  input  logic [WORD_W-1:0]                             tok_data_i,
  input  logic [ACT_W-1:0]                              act_id_i,
  input  logic [SIZE_W-1:0]                             act_size_i,
  input  logic [TGT_W-1:0]                              act_target_i,
  input  logic                                          act_dir_i,
  input  logic [CLK_W-1:0]                              epoch_i,
  output logic                                          dig_req_o,
  output logic [ACT_W+SIZE_W+TGT_W+1+CLK_W+NONCE_W-1:0] dig_msg_o,
  input  logic                                          dig_ack_i,
  input  logic [TAG_W-1:0]                              dig_tag_i,
  output logic                                          proceed_o,
  output logic [2:0]                                    reason_o
);
  localparam int COV_W    = ACT_W + SIZE_W + TGT_W + 1 + CLK_W + NONCE_W;
  localparam int TOK_W    = COV_W + TAG_W;
  localparam int NWORDS   = (TOK_W + WORD_W - 1) / WORD_W;
  localparam int BUF_W    = NWORDS * WORD_W;
  localparam int WCNT_W   = $clog2(NWORDS + 1);
  localparam int WIN_W    = $clog2(WIN + 1);
  localparam int NONCE_LO = TAG_W;
  localparam int CLK_LO   = NONCE_LO + NONCE_W;
  localparam int DIR_LO   = CLK_LO + CLK_W;
  localparam int TGT_LO   = DIR_LO + 1;
  localparam int SIZE_LO  = TGT_LO + TGT_W;
  localparam int ACT_LO   = SIZE_LO + SIZE_W;

  state_e              st_q;
  logic [WCNT_W-1:0]   wcnt_q;
  logic [BUF_W-1:0]    buf_q;
  logic [TAG_W-1:0]    tag_q;
  logic [WIN_W-1:0]    win_q;
  reason_e             reason_q;
  reason_e             verdict;

  logic [TAG_W-1:0]   t_tag;
  logic [NONCE_W-1:0] t_nonce;
  logic [CLK_W-1:0]   t_clk;
  logic               t_dir;
  logic [TGT_W-1:0]   t_tgt;
  logic [SIZE_W-1:0]  t_size;
  logic [ACT_W-1:0]   t_act;
  logic               unused_pad;

  logic cmp_start, cmp_done, cmp_match;
  logic st_hit, st_full, st_insert;
  logic stale, mismatch;

  assign t_tag      = buf_q[TAG_W-1:0];
  assign t_nonce    = buf_q[NONCE_LO +: NONCE_W];
  assign t_clk      = buf_q[CLK_LO +: CLK_W];
  assign t_dir      = buf_q[DIR_LO];
  assign t_tgt      = buf_q[TGT_LO +: TGT_W];
  assign t_size     = buf_q[SIZE_LO +: SIZE_W];
  assign t_act      = buf_q[ACT_LO +: ACT_W];
  assign unused_pad = ^buf_q[BUF_W-1:TOK_W];

  assign cmp_start = (st_q == ST_DIG) && dig_ack_i;

  auth_tag_cmp #(.TAG_W(TAG_W)) i_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmp_start),
    .a_i     (t_tag),
    .b_i     (tag_q),
    .done_o  (cmp_done),
    .match_o (cmp_match)
  );

  auth_nonce_store #(.DEPTH(DEPTH), .NONCE_W(NONCE_W)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .nonce_i  (t_nonce),
    .insert_i (st_insert),
    .hit_o    (st_hit),
    .full_o   (st_full)
  );

  assign stale    = (t_clk < epoch_i);
  assign mismatch = (t_act != act_id_i) || (t_size != act_size_i) ||
                    (t_tgt != act_target_i) || (t_dir != act_dir_i);

  // fixed priority, fail closed
  always_comb begin
    if (!cmp_match)   verdict = RSN_MAC;
    else if (st_hit)  verdict = RSN_REPLAY;
    else if (stale)   verdict = RSN_STALE;
    else if (mismatch) verdict = RSN_MISMATCH;
    else if (st_full) verdict = RSN_FULL;
    else              verdict = RSN_NONE;
  end

  assign st_insert = (st_q == ST_CMP) && cmp_done && (verdict == RSN_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_RX;
      wcnt_q   <= '0;
      buf_q    <= '0;
      tag_q    <= '0;
      win_q    <= '0;
      reason_q <= RSN_NONE;
    end else begin
      unique case (st_q)
        ST_RX: if (tok_valid_i) begin
          buf_q <= {buf_q[BUF_W-WORD_W-1:0], tok_data_i};
          if (wcnt_q == WCNT_W'(NWORDS - 1)) begin
            wcnt_q <= '0;
            st_q   <= ST_DIG;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        ST_DIG: if (dig_ack_i) begin
          tag_q <= dig_tag_i;
          st_q  <= ST_CMP;
        end
        ST_CMP: if (cmp_done) begin
          reason_q <= verdict;
          win_q    <= '0;
          st_q     <= (verdict == RSN_NONE) ? ST_GRANT : ST_RX;
        end
        ST_GRANT: begin
          if (win_q == WIN_W'(WIN - 1)) st_q  <= ST_RX;
          else                          win_q <= win_q + 1'b1;
        end
        default: st_q <= ST_RX;
      endcase
    end
  end

  assign tok_ready_o = (st_q == ST_RX);
  assign dig_req_o   = (st_q == ST_DIG);
  assign dig_msg_o   = buf_q[TOK_W-1:TAG_W];
  assign proceed_o   = (st_q == ST_GRANT);
  assign reason_o    = reason_q;
endmodule

// File: rtl/auth_token_checker_sva.sv
module auth_token_checker_sva #(
  parameter int WIN   = 16,
  parameter int COV_W = 89
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tok_valid_i,
  input logic             tok_ready_o,
  input logic             dig_req_o,
  input logic             dig_ack_i,
  input logic [COV_W-1:0] dig_msg_o,
  input logic             proceed_o,
  input logic [2:0]       reason_o
);
  localparam int RUN_W = $clog2(WIN + 1);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (proceed_o) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  assert_ready_after_xfer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tok_ready_o) |-> $past(tok_valid_i));

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_req_o && !dig_ack_i |=> dig_req_o && $stable(dig_msg_o));

  assert_reject_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reason_o != 3'd0) |-> !proceed_o);

  assert_reason_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reason_o <= 3'd5);

  assert_grant_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(proceed_o) |-> reason_o == 3'd0);

  assert_busy_in_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proceed_o |-> !tok_ready_o && !dig_req_o);

  assert_window_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proceed_o |-> run_q < RUN_W'(WIN));
endmodule

bind auth_token_checker auth_token_checker_sva #(.WIN(WIN), .COV_W(COV_W)) i_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tok_valid_i (tok_valid_i),
  .tok_ready_o (tok_ready_o),
  .dig_req_o   (dig_req_o),
  .dig_ack_i   (dig_ack_i),
  .dig_msg_o   (dig_msg_o),
  .proceed_o   (proceed_o),
  .reason_o    (reason_o)
);

// File: tb/test_auth_token_checker.sv
module test_auth_token_checker;
  localparam int CLK_PERIOD = 10;
  localparam int WIN   = 16;
  localparam int DEPTH = 8;
  localparam int NB    = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tok_valid_i = 1'b0;
  logic         tok_ready_o;
  logic [31:0]  tok_data_i = '0;
  logic [7:0]   d_act = '0;
  logic [15:0]  d_size = '0, d_tgt = '0, epoch = '0;
  logic         d_dir = 1'b0;
  logic         dig_req_o, dig_ack_i = 1'b0;
  logic [88:0]  dig_msg_o;
  logic [63:0]  dig_tag_i = '0;
  logic         proceed_o;
  logic [2:0]   reason_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] used [DEPTH];
  int          used_cnt = 0;
  int          seq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  auth_token_checker #(.WIN(WIN), .DEPTH(DEPTH)) i_auth_token_checker (
    .clk_i(clk), .rst_ni(rst_ni), .tok_valid_i(tok_valid_i), .tok_ready_o(tok_ready_o),
    .tok_data_i(tok_data_i), .act_id_i(d_act), .act_size_i(d_size), .act_target_i(d_tgt),
    .act_dir_i(d_dir), .epoch_i(epoch), .dig_req_o(dig_req_o), .dig_msg_o(dig_msg_o),
    .dig_ack_i(dig_ack_i), .dig_tag_i(dig_tag_i), .proceed_o(proceed_o), .reason_o(reason_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mac_of(logic [88:0] m);
    logic [127:0] x = {39'd0, m};
    return (x[63:0] * 64'h9E3779B97F4A7C15) ^ {x[127:64] * 64'hC2B2AE3D27D4EB4F} ^ 64'h5A5A_0F0F_3C3C_A5A5;
  endfunction

  function automatic bit is_used(logic [31:0] n);
    for (int i = 0; i < used_cnt; i++) if (used[i] == n) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int model(logic [7:0] a, logic [15:0] s, logic [15:0] t, logic dr,
                               logic [15:0] c, logic [31:0] n, logic [63:0] flip);
    if (flip != 0) return 1;
    if (is_used(n)) return 2;
    if (c < epoch) return 3;
    if (a != d_act || s != d_size || t != d_tgt || dr != d_dir) return 4;
    if (used_cnt == DEPTH) return 5;
    return 0;
  endfunction

  function automatic string req_of(int code);
    case (code)
      0: return "R10";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R9";
    endcase
  endfunction

  // drives one token, serves the digest, returns the verdict
  task automatic run_case(input logic [7:0] a, input logic [15:0] s, input logic [15:0] t,
                          input logic dr, input logic [15:0] c, input logic [31:0] n,
                          input logic [63:0] flip, output int got);
    logic [88:0]  cov = {a, s, t, dr, c, n};
    logic [159:0] tok = {7'd0, cov, mac_of(cov) ^ flip};
    int exp = model(a, s, t, dr, c, n, flip);
    int lat, win;
    @(negedge clk);
    for (int w = 0; w < 5; w++) begin
      while (!tok_ready_o) @(negedge clk);
      tok_valid_i = 1'b1;
      tok_data_i  = tok[159-32*w -: 32];
      @(negedge clk);
    end
    tok_valid_i = 1'b0;
    while (!dig_req_o) @(negedge clk);
    check("R2 R3 digest message", int'(dig_msg_o == cov), 1);
    repeat ($urandom % 4) @(negedge clk);
    check("R3 request held", int'(dig_req_o), 1);
    dig_ack_i = 1'b1;
    dig_tag_i = mac_of(cov);
    @(negedge clk);
    dig_ack_i = 1'b0;
    dig_tag_i = $urandom;
    lat = 1;
    while (!tok_ready_o && !proceed_o) begin
      @(negedge clk);
      lat++;
    end
    check("R11 verdict latency", lat, NB + 1);
    win = 0;
    while (proceed_o) begin
      win++;
      @(negedge clk);
    end
    got = reason_o;
    check(req_of(exp), got, exp);
    check("R10 window length", win, (exp == 0) ? WIN : 0);
    if (exp == 0 && used_cnt < DEPTH) begin
      used[used_cnt] = n;
      used_cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int got;
    void'($urandom(32'd20240611));
    d_act = 8'h21; d_size = 16'd500; d_tgt = 16'h0A0B; d_dir = 1'b1; epoch = 16'd100;
    repeat (3) @(negedge clk);
    check("R1 reset proceed", int'(proceed_o), 0);
    check("R1 reset ready", int'(tok_ready_o), 1);
    check("R1 reset reason", int'(reason_o), 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 idle proceed low", int'(proceed_o), 0);

    run_case(8'h21, 16'd500, 16'h0A0B, 1'b1, 16'd100, 32'd100, 64'd0, got);
    run_case(8'h21, 16'd500, 16'h0A0B, 1'b1, 16'd105, 32'd100, 64'd0, got);
    run_case(8'h21, 16'd500, 16'h0A0B, 1'b1, 16'd99,  32'd200, 64'd0, got);
    // R9 refused nonce 200 still free; R6 equal epoch passes
    run_case(8'h21, 16'd500, 16'h0A0B, 1'b1, 16'd100, 32'd200, 64'd0, got);
    check("R9 no consume on reject", got, 0);
    run_case(8'h22, 16'd500, 16'h0A0B, 1'b1, 16'd120, 32'd300, 64'd0, got);
    run_case(8'h21, 16'd499, 16'h0A0B, 1'b1, 16'd120, 32'd301, 64'd0, got);
    run_case(8'h21, 16'd501, 16'h0A0B, 1'b1, 16'd120, 32'd302, 64'd0, got);
    run_case(8'h21, 16'd500, 16'h0A0C, 1'b1, 16'd120, 32'd303, 64'd0, got);
    run_case(8'h21, 16'd500, 16'h0A0B, 1'b0, 16'd120, 32'd304, 64'd0, got);
    run_case(8'h21, 16'd500, 16'h0A0B, 1'b1, 16'd120, 32'd305, 64'h0000_0000_0000_0080, got);
    run_case(8'h21, 16'd500, 16'h0A0B, 1'b1, 16'd120, 32'd306, 64'h0100_0000_0000_0000, got);
    run_case(8'h22, 16'd500, 16'h0A0B, 1'b1, 16'd50,  32'd307, 64'h0000_0010_0000_0000, got);
    check("R8 MAC over stale and mismatch", got, 1);
    run_case(8'h21, 16'd500, 16'h0A0B, 1'b1, 16'd50,  32'd100, 64'd0, got);
    check("R8 replay over stale", got, 2);
    run_case(8'h23, 16'd500, 16'h0A0B, 1'b1, 16'd50,  32'd308, 64'd0, got);
    check("R8 stale over mismatch", got, 3);

    for (int i = 0; i < 40; i++) begin
      logic [7:0]  a;
      logic [15:0] s, t, c;
      logic        dr;
      logic [31:0] n;
      logic [63:0] flip = 64'd0;
      int f = (($urandom % 3) == 0) ? 0 : int'($urandom % 16);
      d_act = 8'($urandom); d_size = 16'($urandom); d_tgt = 16'($urandom); d_dir = 1'($urandom);
      epoch = 16'(16 + $urandom % 1000);
      a = d_act; s = d_size; t = d_tgt; dr = d_dir;
      c = epoch + 16'($urandom % 4);
      n = 32'h1000_0000 + 32'(seq); seq++;
      if (f[0]) flip = 64'd1 << ($urandom % 64);
      if (f[1] && used_cnt > 0) n = used[$urandom % used_cnt];
      if (f[2]) c = epoch - 16'(1 + $urandom % 4);
      if (f[3]) case ($urandom % 4)
        0: a = a ^ 8'h01;
        1: s = s + 16'd1;
        2: t = t ^ 16'h8000;
        default: dr = ~dr;
      endcase
      run_case(a, s, t, dr, c, n, flip, got);
    end

    d_act = 8'h40; d_size = 16'd7; d_tgt = 16'h1234; d_dir = 1'b0; epoch = 16'd300;
    while (used_cnt < DEPTH) begin
      run_case(8'h40, 16'd7, 16'h1234, 1'b0, 16'd300, 32'h2000_0000 + 32'(seq), 64'd0, got);
      seq++;
    end
    run_case(8'h40, 16'd7, 16'h1234, 1'b0, 16'd300, 32'h3000_0001, 64'd0, got);
    check("R9 table full refusal", got, 5);
    run_case(8'h40, 16'd7, 16'h1234, 1'b0, 16'd300, 32'h3000_0002, 64'hFF, got);
    check("R8 MAC over full", got, 1);
    run_case(8'h40, 16'd7, 16'h1234, 1'b0, 16'd300, used[DEPTH-1], 64'd0, got);
    check("R8 replay over full", got, 2);
    repeat (5) @(negedge clk);
    check("R1 no token proceed low", int'(proceed_o), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule